// File: doc/BRIEF.md
# Free-Running Tick Timer with One Compare Channel

This block keeps a 64-bit tick count that advances once per clock and offers one 32-bit compare channel. Software reaches it through a plain 32-bit register port (byte address, write strobe, write data, registered read data). It reads the count as two 32-bit words, loads a target into the compare word, turns comparison on, and acknowledges a hit by writing one to a flag bit in the control/status word. While a hit is latched and comparison is on, the interrupt output is high.

The intended use is one-shot. On each interrupt, software turns comparison off and acknowledges the flag. To schedule the next event it writes the current low count plus a delta into the compare word and turns comparison back on. To get a coherent 64-bit value it reads the high word, then the low word, then the high word again, and retries if the two high reads differ. This works because the high word moves only when the low word rolls over from all ones to zero.

Top module: `tick_timer`

## Requirements
- R1: A synchronous active-high reset loads the count with parameter RST_COUNT (zero by default) and clears the compare word, the match flag, the compare enable, the read data and the interrupt output.
- R2: Word offsets are decoded from the byte address. 0x00 is control/status (bit 0 match flag, bit 4 compare enable, other bits read 0). 0x04 is the count low word, 0x08 is the count high word and 0x0C is the compare word. Read data appears on the clock edge that samples the address, and shows the register value from the cycle before that edge.
- R3: The count rises by exactly one every clock. The high word changes only on the edge where the low word goes from 0xFFFFFFFF to 0.
- R4: Writes to the two count words are ignored, and the count keeps advancing by one.
- R5: An address that is not one of the four word offsets (including any address with bit 1 or bit 0 set) reads 0 and ignores writes.
- R6: The match flag sets on an edge where, before that edge, the compare enable is 1 and the count low word equals the compare word. It stays set until it is acknowledged.
- R7: While the compare enable is 0, an equal count does not set the flag.
- R8: Writing control/status with bit 0 = 1 clears the flag, and bit 0 = 0 leaves it unchanged. If a match and a clear fall on the same edge, the flag ends up set.
- R9: The interrupt output is registered and equals the AND of the match flag and the compare enable after each edge.
- R10: A target of the current low count plus a delta, written in one cycle and enabled in the next, is hit for deltas from 6 upward. This includes targets that wrap past 0xFFFFFFFF.
- R11: A write to control/status loads the compare enable from bit 4. The other written bits (apart from the bit 0 clear) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Registered read data for the address of the previous cycle |
| irq | output | 1 | Level interrupt, high while a match is latched and enabled |

## Verification
The bench starts the count just below a low-word rollover. This lets it observe the high word step from 0 to 1 and the low word wrap to 0, and it also lets it try a compare target that lies past the wrap. That target separates a full 32-bit equality from any magnitude test. A minimum-delta arm of 6 checks how the compare write and the enable write line up with the count. A clear issued on the same edge as a hit shows which of the two wins. Writes with stray bits, writes to the count words and writes to unmapped or misaligned addresses show whether any of these leak into state. Throughout the run, a behavioural model predicts the read data and the interrupt output on every clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    WORD_CTRL  = 2'd0,
    WORD_CNTLO = 2'd1,
    WORD_CNTHI = 2'd2,
    WORD_CMP   = 2'd3
  } word_sel_e;

  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 4;

endpackage

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int          CNT_W     = 64,
  parameter int          LO_W      = 32,
  parameter logic [63:0] RST_COUNT = 64'd0
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [LO_W-1:0]       cnt_lo,
  output logic [CNT_W-LO_W-1:0] cnt_hi
);
  localparam int HI_W = CNT_W - LO_W;

  logic lo_wrap;
  assign lo_wrap = &cnt_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= RST_COUNT[LO_W-1:0];
      cnt_hi <= RST_COUNT[CNT_W-1:LO_W];
    end else begin
      cnt_lo <= cnt_lo + 1'b1;
      if (lo_wrap) cnt_hi <= cnt_hi + {{(HI_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/tick_timer_compare.sv
module tick_timer_compare
  import tick_timer_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_cmp,
  input  logic [BUS_W-1:0] wdata,
  input  logic [BUS_W-1:0] cnt_lo,
  output logic [BUS_W-1:0] cmp_q,
  output logic             en_q,
  output logic             flag_q,
  output logic             irq_q
);
  logic hit, clr, flag_d, en_d;

  assign hit    = en_q && (cnt_lo == cmp_q);
  assign clr    = wr_ctrl && wdata[FLAG_BIT];
  assign flag_d = hit ? 1'b1 : (clr ? 1'b0 : flag_q);
  assign en_d   = wr_ctrl ? wdata[EN_BIT] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_cmp) cmp_q <= wdata;
      en_q   <= en_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & en_d;
    end
  end
endmodule

// File: rtl/tick_timer_regbank.sv
module tick_timer_regbank
  import tick_timer_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int HI_W   = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BUS_W-1:0]  cnt_lo,
  input  logic [HI_W-1:0]   cnt_hi,
  input  logic [BUS_W-1:0]  cmp,
  input  logic              flag,
  input  logic              en,
  output logic              wr_ctrl,
  output logic              wr_cmp,
  output logic [BUS_W-1:0]  rdata
);
  logic      mapped;
  word_sel_e sel;
  logic [BUS_W-1:0] rd_d;

  assign sel = word_sel_e'(addr[3:2]);

  generate
    if (ADDR_W > 4) begin : g_upper
      assign mapped = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:4] == '0);
    end else begin : g_exact
      assign mapped = (addr[1:0] == 2'b00);
    end
  endgenerate

  assign wr_ctrl = we && mapped && (sel == WORD_CTRL);
  assign wr_cmp  = we && mapped && (sel == WORD_CMP);

  always_comb begin
    rd_d = '0;
    if (mapped) begin
      unique case (sel)
        WORD_CTRL: begin
          rd_d[FLAG_BIT] = flag;
          rd_d[EN_BIT]   = en;
        end
        WORD_CNTLO: rd_d = cnt_lo;
        WORD_CNTHI: rd_d = BUS_W'(cnt_hi);
        WORD_CMP:   rd_d = cmp;
        default:    rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int          BUS_W     = 32,
  parameter int          CNT_W     = 64,
  parameter int          ADDR_W    = 6,
  parameter logic [63:0] RST_COUNT = 64'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [BUS_W-1:0] cnt_lo_w, cmp_w;
  logic [HI_W-1:0]  cnt_hi_w;
  logic             flag_w, en_w, wr_ctrl_w, wr_cmp_w;

  tick_timer_counter #(.CNT_W(CNT_W), .LO_W(BUS_W), .RST_COUNT(RST_COUNT)) u_cnt (
    .clk(clk), .rst(rst), .cnt_lo(cnt_lo_w), .cnt_hi(cnt_hi_w)
  );

  tick_timer_regbank #(.BUS_W(BUS_W), .HI_W(HI_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we),
    .cnt_lo(cnt_lo_w), .cnt_hi(cnt_hi_w), .cmp(cmp_w), .flag(flag_w), .en(en_w),
    .wr_ctrl(wr_ctrl_w), .wr_cmp(wr_cmp_w), .rdata(bus_rdata)
  );

  tick_timer_compare #(.BUS_W(BUS_W)) u_cmp (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl_w), .wr_cmp(wr_cmp_w), .wdata(bus_wdata),
    .cnt_lo(cnt_lo_w), .cmp_q(cmp_w), .en_q(en_w), .flag_q(flag_w), .irq_q(irq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int BUS_W  = 32,
  parameter int HI_W   = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq,
  input logic [BUS_W-1:0]  cnt_lo,
  input logic [HI_W-1:0]   cnt_hi,
  input logic [BUS_W-1:0]  cmp,
  input logic              flag,
  input logic              en
);
  logic sel_hi, clr_wr;
  assign sel_hi = (bus_addr == ADDR_W'(8));
  assign clr_wr = bus_we && (bus_addr == '0) && bus_wdata[0];

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1);

  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(en && (cnt_lo == cmp)));

  assert_flag_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(flag)) |-> $past(clr_wr));

  assert_irq_and_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && en));

  assert_read_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_hi)) |-> bus_rdata == BUS_W'($past(cnt_hi)));
endmodule

bind tick_timer tick_timer_chk #(.BUS_W(BUS_W), .HI_W(HI_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .cnt_lo(cnt_lo_w), .cnt_hi(cnt_hi_w),
  .cmp(cmp_w), .flag(flag_w), .en(en_w)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam logic [63:0] START = 64'h0000_0000_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit started = 0;

  always #2 clk = ~clk;

  tick_timer #(.RST_COUNT(START)) u_tick_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference
  longint unsigned m_cnt;
  logic [31:0] m_cmp, m_rd;
  bit m_en, m_flag, m_irq;

  always @(posedge clk) begin
    int idx;
    bit hit, nf, ne;
    if (rst) begin
      m_cnt = START; m_cmp = 0; m_en = 0; m_flag = 0; m_irq = 0; m_rd = 0;
    end else begin
      idx = (bus_addr[1:0] == 0) ? int'(bus_addr >> 2) : 99;
      case (idx)
        0: m_rd = (32'(m_en) << 4) | 32'(m_flag);
        1: m_rd = m_cnt[31:0];
        2: m_rd = m_cnt[63:32];
        3: m_rd = m_cmp;
        default: m_rd = 0;
      endcase
      hit = m_en && (m_cnt[31:0] == m_cmp);
      nf = m_flag;
      if (bus_we && idx == 0 && bus_wdata[0]) nf = 0;
      if (hit) nf = 1;
      ne = (bus_we && idx == 0) ? bus_wdata[4] : m_en;
      if (bus_we && idx == 3) m_cmp = bus_wdata;
      m_flag = nf; m_en = ne; m_irq = nf & ne;
      m_cnt = m_cnt + 1;
    end
    started = 1;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (started) begin
    chk(32'(irq), 32'(m_irq), "R9 irq vs model");
    chk(bus_rdata, m_rd, "R2 rdata vs model");
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); bus_we = 0; end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_we = 0;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic arm(input logic [31:0] delta);
    @(negedge clk); bus_addr = 6'h0C; bus_we = 1; bus_wdata = m_cnt[31:0] + delta;
    @(negedge clk); bus_addr = 6'h00; bus_we = 1; bus_wdata = 32'h10;
  endtask

  initial begin
    logic [31:0] v, v2;
    int waited;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(32'(irq), 0, "R1 irq after reset");
    rd(6'h00, v); chk(v, 0, "R1 ctrl after reset");
    rd(6'h0C, v); chk(v, 0, "R1 compare after reset");
    rd(6'h08, v); chk(v, 0, "R1 high word before wrap");
    rd(6'h04, v); rd(6'h04, v2); chk(v2 - v, 2, "R3 low step over two reads");
    // R4: writes to count words ignored
    wr(6'h04, 32'h1234_5678); wr(6'h08, 32'hDEAD_BEEF);
    rd(6'h08, v); chk(v, 0, "R4 high word after write");
    // R5: unmapped / misaligned
    wr(6'h10, 32'hFFFF_FFFF); wr(6'h01, 32'hFFFF_FFFF);
    rd(6'h10, v); chk(v, 0, "R5 unmapped read");
    rd(6'h3C, v); chk(v, 0, "R5 top unmapped read");
    rd(6'h0D, v); chk(v, 0, "R5 misaligned read");
    rd(6'h00, v); chk(v, 0, "R5 ctrl untouched by stray writes");
    // R11: stray bits ignored, bit 4 clear
    wr(6'h00, 32'hFFFF_FFEE);
    rd(6'h00, v); chk(v, 0, "R11 ctrl after stray bits");
    // R7: equal count while disabled
    @(negedge clk); bus_addr = 6'h0C; bus_we = 1; bus_wdata = m_cnt[31:0] + 3;
    idle(10);
    rd(6'h00, v); chk(v, 0, "R7 no flag while disabled");
    // R10 wrap-past target
    arm(32'h180);
    idle(1); waited = 0;
    while (!irq && waited < 600) begin @(negedge clk); waited++; end
    chk(32'(irq), 1, "R10 wrapped target hit");
    rd(6'h00, v); chk(v, 32'h11, "R6 ctrl after match");
    rd(6'h08, v); chk(v, 1, "R3 high word after wrap");
    // R8: writing 0 to bit 0 keeps flag
    wr(6'h00, 32'h10);
    rd(6'h00, v); chk(v, 32'h11, "R8 write zero keeps flag");
    wr(6'h00, 32'h00); idle(1);
    chk(32'(irq), 0, "R9 irq masked by enable");
    rd(6'h00, v); chk(v, 32'h01, "R9 flag held with enable off");
    wr(6'h00, 32'h01);
    rd(6'h00, v); chk(v, 0, "R8 write one clears");
    // R10 minimum delta
    arm(32'd6); idle(6);
    chk(32'(irq), 1, "R10 delta 6 hit");
    wr(6'h00, 32'h11);
    rd(6'h00, v); chk(v, 32'h10, "R8 clear keeps enable");
    // R8 simultaneous set and clear
    arm(32'd4); idle(2); wr(6'h00, 32'h11); idle(1);
    rd(6'h00, v); chk(v, 32'h11, "R8 set wins over clear");
    wr(6'h00, 32'h01); idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule